// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block runs the refresh side of a multi-bank mobile DRAM controller. A free-running interval timer raises a refresh request. When the request is taken, the block checks whether any bank is still open. If one is, it first issues a precharge-all command and waits the row-precharge time. It then issues an auto-refresh command and holds off the main controller for the refresh cycle time. The row and bank to refresh come from an internal counter. The counter walks every bank at one row before it moves to the next row, so requesters never supply a bank address.

The block also handles self-refresh. While the low-power request input is held high, the block closes any open banks and then issues a self-refresh entry command. It then stays quiet while the device refreshes itself. When the request drops, it issues the exit command and waits a programmable recovery time. It then performs one auto-refresh before it hands the bus back. A keep mask, captured at the moment of entry, names the banks that self-refresh preserves. At exit, the contents of every other bank are reported as lost. All timing values are run-time inputs, measured in clock cycles.

Top module: `rfc_refresh_ctrl`

## Requirements
- R1: With all banks closed and no self-refresh request, an auto-refresh command is issued once every `t_refi` cycles.
- R2: When a refresh is taken while any bit of `bank_open` is set, a precharge-all command comes first, and the auto-refresh follows exactly `t_rp` cycles later. With all banks closed, no precharge-all is issued.
- R3: `busy` is high from the first command of a sequence onward. After an auto-refresh, `busy` falls exactly `t_rfc` cycles after that command.
- R4: Each auto-refresh presents `ref_bank`/`ref_row`. Successive refreshes step the bank from 0 to NB-1 at a fixed row, then advance the row. After the last row the row wraps to 0.
- R5: `refresh_overdue` rises when the interval expires again while a request is still unserved. It stays low when each request is served within its interval.
- R6: With `sr_req` high and no refresh pending, open banks are first precharged. Then a self-refresh entry command is issued and `in_self_refresh` goes high. No command is issued and `refresh_overdue` stays low until `sr_req` drops.
- R7: When `sr_req` falls during self-refresh, an exit command is issued, and one auto-refresh follows exactly `t_xsr` cycles later. Periodic refresh then resumes.
- R8: `keep_mask` is sampled at the self-refresh entry command. At the exit command, every `bank_valid` bit whose sampled mask bit is 0 is cleared. Later mask changes have no effect, and `bank_valid` bits never rise except through reset.
- R9: During and right after reset, `cmd_valid`, `busy`, `refresh_overdue` and `in_self_refresh` are 0 and `bank_valid` is all ones.
- R10: `cmd_code` is valid when `cmd_valid` is high. The codes are 1 for precharge-all, 2 for auto-refresh, 3 for self-refresh entry and 4 for self-refresh exit. Each command lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_refi | input | TW | Refresh interval in cycles |
| t_rp | input | TW | Precharge-to-refresh time in cycles (minimum 2) |
| t_rfc | input | TW | Refresh cycle time in cycles (minimum 2) |
| t_xsr | input | TW | Self-refresh exit recovery in cycles (minimum 2) |
| bank_open | input | NB | Per-bank open flag from the main controller |
| sr_req | input | 1 | Level request to stay in self-refresh |
| keep_mask | input | NB | Banks to preserve during self-refresh |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_code | output | 3 | Command code (see R10) |
| ref_bank | output | clog2(NB) | Bank of the current refresh address |
| ref_row | output | clog2(ROWS) | Row of the current refresh address |
| busy | output | 1 | Refresh sequence or self-refresh in progress; blocks activates |
| refresh_overdue | output | 1 | A refresh interval was missed |
| in_self_refresh | output | 1 | Device is held in self-refresh |
| bank_valid | output | NB | Per-bank flag that contents are still intact |

## Verification
The sequencer is first driven with every bank closed, which shows the bare interval spacing and the counter stepping through bank, row and wrap. It is then driven with one bank left open, which separates the direct path from the precharge-first path by the `t_rp` gap. A self-refresh visit runs with an open bank and a partial keep mask that is altered mid-visit. This tells a mask sampled at entry from one read live, and shows the exit recovery gap. Finally, the interval is shrunk below the refresh cycle time, which provokes the overdue flag that the earlier phases must never show.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_PRE_ALL  = 3'd1,
    CMD_AUTO_REF = 3'd2,
    CMD_SR_ENTER = 3'd3,
    CMD_SR_EXIT  = 3'd4
  } rfc_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT_RP,
    ST_AREF,
    ST_WAIT_RFC,
    ST_SR_ENTER,
    ST_SELF,
    ST_SR_EXIT,
    ST_WAIT_XSR
  } rfc_state_e;

endpackage

// File: rtl/rfc_interval_timer.sv
module rfc_interval_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          ack,
  input  logic [TW-1:0] t_refi,
  output logic          tick,
  output logic          pending,
  output logic          overdue
);

  logic [TW-1:0] cnt;

  // interval ends on the last count; tolerant of a limit lowered mid-interval
  function automatic logic interval_done(input logic [TW-1:0] c, input logic [TW-1:0] lim);
    if (lim <= TW'(1)) return 1'b1;
    return c >= (lim - TW'(1));
  endfunction

  assign tick = !hold && interval_done(cnt, t_refi);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      cnt     <= '0;
      pending <= 1'b0;
      overdue <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + TW'(1);
      if (tick)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
      if (tick && pending && !ack) overdue <= 1'b1;
      else if (ack)                overdue <= 1'b0;
    end
  end

  AST_TICK_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pending); // R1
  AST_OVERDUE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    overdue |-> pending); // R5

endmodule

// File: rtl/rfc_addr_counter.sv
module rfc_addr_counter #(
  parameter int NB   = 4,
  parameter int ROWS = 8192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  output logic [$clog2(NB)-1:0]   bank,
  output logic [$clog2(ROWS)-1:0] row
);

  localparam int BANK_W = $clog2(NB);
  localparam int ROW_W  = $clog2(ROWS);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NB - 1);
  localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);

  function automatic logic [BANK_W-1:0] bank_after(input logic [BANK_W-1:0] b);
    return (b == LAST_BANK) ? '0 : b + BANK_W'(1);
  endfunction

  function automatic logic [ROW_W-1:0] row_after(input logic [ROW_W-1:0] r,
                                                 input logic [BANK_W-1:0] b);
    if (b != LAST_BANK) return r;
    return (r == LAST_ROW) ? '0 : r + ROW_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank <= '0;
      row  <= '0;
    end else if (adv) begin
      bank <= bank_after(bank);
      row  <= row_after(row, bank);
    end
  end

  AST_ROW_WAITS_FOR_LAST_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && bank != LAST_BANK) |=> $stable(row)); // R4
  AST_ADDR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(row) && $stable(bank))); // R4

endmodule

// File: rtl/rfc_sequencer.sv
module rfc_sequencer
  import rfc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pending,
  input  logic          any_open,
  input  logic          sr_req,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_rfc,
  input  logic [TW-1:0] t_xsr,
  output logic          cmd_valid,
  output rfc_cmd_e      cmd,
  output logic          busy,
  output logic          in_self_refresh,
  output logic          timer_hold,
  output logic          aref_fire,
  output logic          sre_fire,
  output logic          srx_fire
);

  rfc_state_e    state, nxt;
  logic [TW-1:0] wcnt;
  logic          goal_sr;
  logic          wait_done;

  // command at cycle c, next command at c+t: wait states fill c+1 .. c+t-1
  function automatic logic [TW-1:0] wait_load(input logic [TW-1:0] t);
    return (t < TW'(2)) ? TW'(1) : t - TW'(1);
  endfunction

  assign wait_done = (wcnt <= TW'(1));

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (pending)     nxt = any_open ? ST_PRE : ST_AREF;
        else if (sr_req) nxt = any_open ? ST_PRE : ST_SR_ENTER;
      end
      ST_PRE:      nxt = ST_WAIT_RP;
      ST_WAIT_RP:  if (wait_done) nxt = goal_sr ? ST_SR_ENTER : ST_AREF;
      ST_AREF:     nxt = ST_WAIT_RFC;
      ST_WAIT_RFC: if (wait_done) nxt = ST_IDLE;
      ST_SR_ENTER: nxt = ST_SELF;
      ST_SELF:     if (!sr_req) nxt = ST_SR_EXIT;
      ST_SR_EXIT:  nxt = ST_WAIT_XSR;
      ST_WAIT_XSR: if (wait_done) nxt = ST_AREF;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wcnt    <= '0;
      goal_sr <= 1'b0;
    end else begin
      state <= nxt;
      case (state)
        ST_IDLE: begin
          if (pending)     goal_sr <= 1'b0;
          else if (sr_req) goal_sr <= 1'b1;
        end
        ST_PRE:     wcnt <= wait_load(t_rp);
        ST_AREF:    wcnt <= wait_load(t_rfc);
        ST_SR_EXIT: wcnt <= wait_load(t_xsr);
        ST_WAIT_RP, ST_WAIT_RFC, ST_WAIT_XSR:
          if (wcnt != '0) wcnt <= wcnt - TW'(1);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_PRE:      cmd = CMD_PRE_ALL;
      ST_AREF:     cmd = CMD_AUTO_REF;
      ST_SR_ENTER: cmd = CMD_SR_ENTER;
      ST_SR_EXIT:  cmd = CMD_SR_EXIT;
      default:     cmd = CMD_NOP;
    endcase
  end

  assign cmd_valid       = (cmd != CMD_NOP);
  assign aref_fire       = (state == ST_AREF);
  assign sre_fire        = (state == ST_SR_ENTER);
  assign srx_fire        = (state == ST_SR_EXIT);
  assign busy            = (state != ST_IDLE);
  assign in_self_refresh = (state == ST_SELF);
  assign timer_hold      = (state == ST_SR_ENTER) || (state == ST_SELF) ||
                           (state == ST_SR_EXIT)  || (state == ST_WAIT_XSR);

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R10
  AST_EXIT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    srx_fire |-> $past(!sr_req)); // R7

endmodule

// File: rtl/rfc_refresh_ctrl.sv
module rfc_refresh_ctrl
  import rfc_pkg::*;
#(
  parameter int TW   = 16,
  parameter int NB   = 4,
  parameter int ROWS = 8192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TW-1:0]           t_refi,
  input  logic [TW-1:0]           t_rp,
  input  logic [TW-1:0]           t_rfc,
  input  logic [TW-1:0]           t_xsr,
  input  logic [NB-1:0]           bank_open,
  input  logic                    sr_req,
  input  logic [NB-1:0]           keep_mask,
  output logic                    cmd_valid,
  output logic [2:0]              cmd_code,
  output logic [$clog2(NB)-1:0]   ref_bank,
  output logic [$clog2(ROWS)-1:0] ref_row,
  output logic                    busy,
  output logic                    refresh_overdue,
  output logic                    in_self_refresh,
  output logic [NB-1:0]           bank_valid
);

  logic     tick, pending, timer_hold;
  logic     aref_fire, sre_fire, srx_fire;
  logic     any_open;
  rfc_cmd_e cmd;
  logic [NB-1:0] keep_snap;

  assign any_open = |bank_open;
  assign cmd_code = cmd;

  rfc_interval_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (timer_hold),
    .ack     (aref_fire),
    .t_refi  (t_refi),
    .tick    (tick),
    .pending (pending),
    .overdue (refresh_overdue)
  );

  rfc_addr_counter #(.NB(NB), .ROWS(ROWS)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (aref_fire),
    .bank  (ref_bank),
    .row   (ref_row)
  );

  rfc_sequencer #(.TW(TW)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .pending         (pending),
    .any_open        (any_open),
    .sr_req          (sr_req),
    .t_rp            (t_rp),
    .t_rfc           (t_rfc),
    .t_xsr           (t_xsr),
    .cmd_valid       (cmd_valid),
    .cmd             (cmd),
    .busy            (busy),
    .in_self_refresh (in_self_refresh),
    .timer_hold      (timer_hold),
    .aref_fire       (aref_fire),
    .sre_fire        (sre_fire),
    .srx_fire        (srx_fire)
  );

  // mask sampled at entry, applied at exit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_snap  <= '1;
      bank_valid <= '1;
    end else begin
      if (sre_fire) keep_snap  <= keep_mask;
      if (srx_fire) bank_valid <= bank_valid & keep_snap;
    end
  end

  AST_REF_SERVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (aref_fire && !tick) |=> !pending); // R1
  AST_VALID_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bank_valid & ~$past(bank_valid)) == '0)); // R8
  AST_SELF_NO_OVERDUE: assert property (@(posedge clk) disable iff (!rst_n)
    in_self_refresh |-> !refresh_overdue); // R6
  AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy); // R3

endmodule

// File: tb/rfc_refresh_ctrl_bench.sv
module rfc_refresh_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TW   = 16;
  localparam int NB   = 4;
  localparam int ROWS = 2;
  localparam int REFI = 40;
  localparam int TRP  = 3;
  localparam int TRFC = 5;
  localparam int TXSR = 7;
  localparam logic [2:0] C_PRE = 3'd1, C_REF = 3'd2, C_SRE = 3'd3, C_SRX = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] t_refi = TW'(REFI), t_rp = TW'(TRP), t_rfc = TW'(TRFC), t_xsr = TW'(TXSR);
  logic [NB-1:0] bank_open = '0, keep_mask = '1;
  logic          sr_req = 1'b0;
  logic          cmd_valid, busy, refresh_overdue, in_self_refresh;
  logic [2:0]    cmd_code;
  logic [1:0]    ref_bank;
  logic [0:0]    ref_row;
  logic [NB-1:0] bank_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfc_refresh_ctrl #(.TW(TW), .NB(NB), .ROWS(ROWS)) u_rfc_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .t_refi(t_refi), .t_rp(t_rp), .t_rfc(t_rfc),
    .t_xsr(t_xsr), .bank_open(bank_open), .sr_req(sr_req), .keep_mask(keep_mask),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .ref_bank(ref_bank), .ref_row(ref_row),
    .busy(busy), .refresh_overdue(refresh_overdue), .in_self_refresh(in_self_refresh),
    .bank_valid(bank_valid)
  );

  typedef struct {
    logic [2:0] cmd;
    int         bank;
    int         row;
    int         gap;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, fails = 0;
  bit   strict = 1'b0, saw_overdue = 1'b0, finished = 1'b0;
  int   cyc = 0, last_cyc = 0;
  logic [2:0] last_cmd = 3'd0;
  logic prev_busy = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] c, input int b, input int r, input int g,
                      input string req);
    exp_t e;
    e.cmd = c; e.bank = b; e.row = r; e.gap = g; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_drain();
    do begin @(negedge clk); #1; end while (exp_q.size() != 0);
  endtask

  task automatic wait_cmd(input logic [2:0] c);
    do @(negedge clk); while (!(cmd_valid && cmd_code == c));
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: pops expected commands and checks gaps and busy release
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      cyc++;
      if (strict && refresh_overdue) saw_overdue = 1'b1;
      if (cmd_valid) begin
        if (strict) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6", "unexpected command", cmd_code, 0);
          end else begin
            e = exp_q.pop_front();
            chk(cmd_code == e.cmd, e.req, "command code", cmd_code, e.cmd);
            if (e.cmd == C_REF) begin
              chk(int'(ref_bank) == e.bank, "R4", "refresh bank", ref_bank, e.bank);
              chk(int'(ref_row) == e.row, "R4", "refresh row", ref_row, e.row);
            end
            if (e.gap != 0)
              chk(cyc - last_cyc == e.gap, e.req, "cycles since previous command",
                  cyc - last_cyc, e.gap);
          end
        end
        last_cyc = cyc;
        last_cmd = cmd_code;
      end
      if (strict && prev_busy && !busy && last_cmd == C_REF)
        chk(cyc - last_cyc == int'(t_rfc), "R3", "busy release after refresh",
            cyc - last_cyc, t_rfc);
      prev_busy = busy;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(!cmd_valid, "R9", "cmd_valid in reset", cmd_valid, 0);
    chk(!busy, "R9", "busy in reset", busy, 0);
    chk(!refresh_overdue, "R9", "overdue in reset", refresh_overdue, 0);
    chk(!in_self_refresh, "R9", "self-refresh in reset", in_self_refresh, 0);
    chk(bank_valid == 4'hF, "R9", "bank_valid in reset", bank_valid, 4'hF);

    strict = 1'b1;
    // R1 periodic refresh with banks closed
    push(C_REF, 0, 0, 0, "R1");
    push(C_REF, 1, 0, REFI, "R1");
    rst_n = 1'b1;
    wait_drain();

    // R2 open bank forces precharge-all first
    bank_open = 4'b0010;
    push(C_PRE, 0, 0, 0, "R2");
    push(C_REF, 2, 0, TRP, "R2");
    wait_cmd(C_PRE);
    bank_open = '0;
    wait_drain();

    // R4 bank-first walk and row wrap (R10 codes checked in each pop)
    push(C_REF, 3, 0, 0, "R10");
    push(C_REF, 0, 1, REFI, "R4");
    push(C_REF, 1, 1, REFI, "R4");
    push(C_REF, 2, 1, REFI, "R4");
    push(C_REF, 3, 1, REFI, "R4");
    push(C_REF, 0, 0, REFI, "R4");
    wait_drain();
    wait_idle();

    // R6 self-refresh entry with an open bank and partial mask
    keep_mask = 4'b0101;
    bank_open = 4'b1000;
    sr_req = 1'b1;
    push(C_PRE, 0, 0, 0, "R6");
    push(C_SRE, 0, 0, TRP, "R6");
    wait_cmd(C_PRE);
    bank_open = '0;
    wait_drain();
    repeat (2) @(negedge clk);
    chk(in_self_refresh, "R6", "in self-refresh", in_self_refresh, 1);
    chk(bank_valid == 4'hF, "R8", "bank_valid before exit", bank_valid, 4'hF);
    keep_mask = 4'hF;   // R8 change after entry is ignored
    repeat (100) @(negedge clk);
    chk(in_self_refresh, "R6", "still in self-refresh", in_self_refresh, 1);
    chk(!refresh_overdue, "R6", "overdue held during self-refresh", refresh_overdue, 0);

    // R7 exit, recovery, one refresh
    push(C_SRX, 0, 0, 0, "R7");
    push(C_REF, 1, 0, TXSR, "R7");
    sr_req = 1'b0;
    wait_drain();
    chk(bank_valid == 4'b0101, "R8", "bank_valid after exit", bank_valid, 4'b0101);
    wait_idle();
    chk(!in_self_refresh, "R7", "left self-refresh", in_self_refresh, 0);
    push(C_REF, 2, 0, 0, "R7");
    wait_drain();
    wait_idle();
    chk(!saw_overdue, "R5", "no overdue with served requests", saw_overdue, 0);

    // R5 interval shorter than refresh cycle
    strict = 1'b0;
    t_refi = TW'(6);
    t_rfc  = TW'(20);
    for (int i = 0; i < 200 && !refresh_overdue; i++) @(negedge clk);
    chk(refresh_overdue, "R5", "overdue raised", refresh_overdue, 1);
    chk(bank_valid == 4'b0101, "R8", "bank_valid stays cleared", bank_valid, 4'b0101);
    summary();
  end

endmodule